// File: doc/BRIEF.md
# DMA Channel FIFO Request Controller

This block holds the data buffer of one DMA channel and decides when the channel should ask the master bus for a source read burst and when it should ask for a destination write burst. Each request comes with a beat count. When the bus accepts a request with a one-cycle grant pulse, that number of beats is reserved. The beats are then pushed into the buffer, or popped out of it, one per cycle.

The block has two request policies. In grouped mode, fills are requested only while the buffer is under half full, and drains only once it is at least half full, so that transfers can travel as bursts. At the end of a block, a flush input lets the leftover data drain even below half. In beat mode, a request is raised as soon as one beat fits or one beat is waiting. A push and a pop can land in the same cycle, which lets the channel fill and drain at once when source and destination sit on separate bus layers.

Top module: `dma_fifo_req_ctrl`

## Requirements
- R1: After reset the occupancy is 0, `full` is low and `dst_req` is low; with `grp_mode` low, `src_req` is high.
- R2: With `grp_mode` low (beat mode), `src_req` is high whenever no source beat is outstanding and occupancy is below the depth, and `src_len` is 1.
- R3: With `grp_mode` low, `dst_req` is high whenever no destination beat is outstanding and occupancy is at least 1, and `dst_len` is 1.
- R4: With `grp_mode` high, `src_req` is raised only while occupancy is below half the depth, and `src_len` equals the effective burst length.
- R5: With `grp_mode` high and `blk_end` low, `dst_req` is raised only while occupancy is at least half the depth and at least the effective burst length; `dst_len` is the effective burst length.
- R6: With `grp_mode` high and `blk_end` high, `dst_req` is also raised for any nonzero occupancy, and `dst_len` is the smaller of occupancy and effective burst length (0 when empty).
- R7: The effective burst length is `burst_len` clamped to the range 1 to half the depth: a value of 0 acts as 1, and values above half act as half.
- R8: A grant pulse taken while its request is high reserves the advertised beat count, and that request stays low until all reserved beats have moved. A grant pulse taken while its request is low has no effect.
- R9: A push or pop strobe with no reserved beat left on its side is ignored: occupancy and output data do not change.
- R10: A push and a pop in the same cycle leave occupancy unchanged and keep the data in order.
- R11: Data leave `dst_data` in the order they were pushed; `dst_data` always shows the oldest held beat.
- R12: Occupancy never exceeds the depth, and `full` is high exactly when occupancy equals the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_mode | input | 1 | 1 = half-full grouped requesting, 0 = single-beat requesting |
| blk_end | input | 1 | Block end: drain the remainder below half |
| burst_len | input | PW+1 | Programmed burst length in beats |
| src_req | output | 1 | Request for a source read burst |
| src_len | output | PW+1 | Beats the source request covers |
| src_grant | input | 1 | One-cycle acceptance of the source request |
| src_push | input | 1 | Source beat valid |
| src_data | input | DW | Source beat data |
| dst_req | output | 1 | Request for a destination write burst |
| dst_len | output | PW+1 | Beats the destination request covers |
| dst_grant | input | 1 | One-cycle acceptance of the destination request |
| dst_pop | input | 1 | Destination takes a beat |
| dst_data | output | DW | Oldest held beat |
| level | output | PW+1 | Current occupancy |
| full | output | 1 | Occupancy equals depth |

## Verification
If the pointers or the occupancy count go wrong, `level` and `full` are off on the first clock edge after the faulty push or pop. The request outputs then flip at the wrong threshold in that same cycle, because they are decoded combinationally from occupancy. A wrong reservation count shows up a little later. Either a request is raised again before the burst has finished, or stray strobes start moving data, and that can be seen on `level` one edge after the extra strobe. Ordering faults appear directly on `dst_data`, which is compared before every pop.

// File: rtl/dma_fifo_req_ctrl.sv
module dma_fifo_req_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_mode,
  input  logic          blk_end,
  input  logic [PW:0]   burst_len,
  output logic          src_req,
  output logic [PW:0]   src_len,
  input  logic          src_grant,
  input  logic          src_push,
  input  logic [DW-1:0] src_data,
  output logic          dst_req,
  output logic [PW:0]   dst_len,
  input  logic          dst_grant,
  input  logic          dst_pop,
  output logic [DW-1:0] dst_data,
  output logic [PW:0]   level,
  output logic          full
);
  localparam logic [PW:0] HALF_V  = (PW+1)'(DEPTH/2);
  localparam logic [PW:0] DEPTH_V = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONE_V   = (PW+1)'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr, rd_ptr, src_left, dst_left, eff_len;
  logic          push_ok, pop_ok;

  always_comb begin
    if (burst_len == '0)        eff_len = ONE_V;
    else if (burst_len > HALF_V) eff_len = HALF_V;
    else                         eff_len = burst_len;
  end

  assign level   = wr_ptr - rd_ptr;
  assign full    = level == DEPTH_V;
  assign push_ok = src_push && src_left != '0;
  assign pop_ok  = dst_pop && dst_left != '0;

  assign src_req = src_left == '0 &&
                   (grp_mode ? (level < HALF_V && (DEPTH_V - level) >= eff_len) : !full);
  assign src_len = grp_mode ? eff_len : ONE_V;

  assign dst_req = dst_left == '0 &&
                   (grp_mode ? ((level >= HALF_V && level >= eff_len) || (blk_end && level != '0))
                             : level != '0);
  assign dst_len = !grp_mode ? ONE_V : (level >= eff_len ? eff_len : level);

  assign dst_data = mem[rd_ptr[PW-1:0]];

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr[PW-1:0]] <= src_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      src_left <= '0;
      dst_left <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + ONE_V;
      if (pop_ok)  rd_ptr <= rd_ptr + ONE_V;
      if (src_grant && src_req) src_left <= src_len;
      else if (push_ok)         src_left <= src_left - ONE_V;
      if (dst_grant && dst_req) dst_left <= dst_len;
      else if (pop_ok)          dst_left <= dst_left - ONE_V;
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_V);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> level != '0);
  // R4
  src_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && grp_mode) |-> level < HALF_V);
  // R5
  dst_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && grp_mode && !blk_end) |-> level >= HALF_V);
  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> level == $past(level));
  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_grant && src_req) |=> !src_req);
endmodule

// File: tb/dma_fifo_req_ctrl_tb.sv
`timescale 1ns/1ps
module dma_fifo_req_ctrl_tb_top;
  localparam int DW = 8, DEPTH = 8, PW = 3, NV = 11;

  logic clk = 0, rst_n = 0, grp_mode = 0, blk_end = 0;
  logic [PW:0] burst_len = 4;
  logic src_grant = 0, src_push = 0, dst_grant = 0, dst_pop = 0;
  logic [DW-1:0] src_data = 0;
  logic src_req, dst_req, full;
  logic [PW:0] src_len, dst_len, level;
  logic [DW-1:0] dst_data;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_fifo_req_ctrl #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .grp_mode(grp_mode), .blk_end(blk_end),
    .burst_len(burst_len), .src_req(src_req), .src_len(src_len),
    .src_grant(src_grant), .src_push(src_push), .src_data(src_data),
    .dst_req(dst_req), .dst_len(dst_len), .dst_grant(dst_grant),
    .dst_pop(dst_pop), .dst_data(dst_data), .level(level), .full(full));

  // {mode, len[3:0], fill[3:0], flush, sreq, dreq, dlen[3:0], slen[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 4'd4, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd1},  // R2 R3 empty
    {1'b0, 4'd4, 4'd8, 1'b0, 1'b0, 1'b1, 4'd1, 4'd1},  // R2 full
    {1'b1, 4'd4, 4'd3, 1'b0, 1'b1, 1'b0, 4'd3, 4'd4},  // R4 below half
    {1'b1, 4'd4, 4'd4, 1'b0, 1'b0, 1'b1, 4'd4, 4'd4},  // R5 at half
    {1'b1, 4'd2, 4'd3, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2},  // R5 under half
    {1'b1, 4'd3, 4'd5, 1'b0, 1'b0, 1'b1, 4'd3, 4'd3},  // R5 above half
    {1'b1, 4'd4, 4'd2, 1'b1, 1'b1, 1'b1, 4'd2, 4'd4},  // R6 flush rest
    {1'b1, 4'd4, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd4},  // R6 flush empty
    {1'b1, 4'd0, 4'd4, 1'b0, 1'b0, 1'b1, 4'd1, 4'd1},  // R7 zero len
    {1'b1, 4'd7, 4'd6, 1'b0, 1'b0, 1'b1, 4'd4, 4'd4},  // R7 long len
    {1'b0, 4'd4, 4'd3, 1'b0, 1'b1, 1'b1, 4'd1, 4'd1}   // R3 beat mode
  };

  task automatic check(input string rq, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; grp_mode = 0; blk_end = 0; burst_len = 4;
    src_grant = 0; src_push = 0; dst_grant = 0; dst_pop = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill_one(input logic [DW-1:0] d);
    @(negedge clk);
    grp_mode = 0; src_grant = 1;
    @(negedge clk);
    src_grant = 0; src_push = 1; src_data = d;
    @(negedge clk);
    src_push = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk); #0.1;
    check("R1 level", int'(level), 0);
    check("R1 full", int'(full), 0);
    check("R1 dst_req", int'(dst_req), 0);
    check("R1 src_req", int'(src_req), 1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      for (int k = 0; k < int'(VEC[i][14:11]); k++) fill_one(DW'(k));
      @(negedge clk);
      grp_mode = VEC[i][19]; burst_len = VEC[i][18:15]; blk_end = VEC[i][10];
      #0.5;
      check($sformatf("R4/R2 src_req v%0d", i), int'(src_req), int'(VEC[i][9]));
      check($sformatf("R5/R3/R6 dst_req v%0d", i), int'(dst_req), int'(VEC[i][8]));
      check($sformatf("R6/R7 dst_len v%0d", i), int'(dst_len), int'(VEC[i][7:4]));
      check($sformatf("R7/R4 src_len v%0d", i), int'(src_len), int'(VEC[i][3:0]));
    end

    // R8 R11 grouped burst fill and drain
    do_reset();
    @(negedge clk);
    grp_mode = 1; burst_len = 4; src_grant = 1;
    @(negedge clk);
    src_grant = 0;
    check("R8 src_req held low", int'(src_req), 0);
    for (int k = 0; k < 4; k++) begin
      src_push = 1; src_data = 8'hA0 + DW'(k);
      @(negedge clk);
    end
    src_push = 0;
    check("R8 level after burst", int'(level), 4);
    check("R5 dst_req at half", int'(dst_req), 1);
    src_push = 1; src_data = 8'hEE;
    @(negedge clk);
    src_push = 0;
    check("R9 push ignored", int'(level), 4);
    dst_pop = 1;
    @(negedge clk);
    dst_pop = 0;
    check("R9 pop ignored level", int'(level), 4);
    check("R9 pop ignored data", int'(dst_data), 'hA0);
    dst_grant = 1;
    @(negedge clk);
    dst_grant = 0;
    check("R8 dst_req held low", int'(dst_req), 0);
    for (int k = 0; k < 4; k++) begin
      check("R11 order", int'(dst_data), 'hA0 + k);
      dst_pop = 1;
      @(negedge clk);
    end
    dst_pop = 0;
    check("R8 level drained", int'(level), 0);

    // R10 concurrent fill and drain
    do_reset();
    fill_one(8'hB0);
    fill_one(8'hB1);
    @(negedge clk);
    src_grant = 1; dst_grant = 1;
    @(negedge clk);
    src_grant = 0; dst_grant = 0;
    check("R10 head before", int'(dst_data), 'hB0);
    src_push = 1; src_data = 8'hB2; dst_pop = 1;
    @(negedge clk);
    src_push = 0; dst_pop = 0;
    check("R10 level unchanged", int'(level), 2);
    check("R10 next head", int'(dst_data), 'hB1);

    // R12 full, R8 grant while request low
    do_reset();
    for (int k = 0; k < DEPTH; k++) fill_one(DW'(k));
    check("R12 full", int'(full), 1);
    check("R12 level", int'(level), DEPTH);
    check("R2 src_req at full", int'(src_req), 0);
    @(negedge clk);
    src_grant = 1;
    @(negedge clk);
    src_grant = 0; src_push = 1; src_data = 8'hFF;
    @(negedge clk);
    src_push = 0;
    check("R8 stray grant ignored", int'(level), DEPTH);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule